// File: doc/BRIEF.md
# Register-Mapped Serial Port with Overrun Policy

This block is an asynchronous serial port that software runs through a 32-bit register bus. One data register feeds the transmitter. Another returns the last byte taken off the receive line. A status word reports three flags: the transmit holding register is free, a received byte is waiting, and a byte was lost. Frames use eight data bits, no parity and one stop bit. A 16-tick oversampling clock times every frame, and that clock comes from a programmable divisor.

When a byte completes while the previous one is still unread, a control bit selects what happens. In one setting the old byte is kept and an overrun error is raised. In the other the new byte quietly replaces the old one. One interrupt line combines the transmit-empty source with the receive source. The receive source covers both a waiting byte and an overrun, and both share a single enable.

Top module: `serial_port_core`

## Requirements
- R1: After reset the status word reads 0x80 (only transmit-empty set), the control and divisor registers read 0, `txd` is high and `irq` is low.
- R2: Registers sit at byte offsets 0x00 control, 0x08 overrun control, 0x0C divisor, 0x1C status, 0x20 flag clear, 0x24 receive data and 0x28 transmit data. Control keeps only bit 0 (port enable), bit 2 (receiver on), bit 3 (transmitter on), bit 5 (receive interrupt enable) and bit 7 (transmit-empty interrupt enable), so writing all ones reads back 0xAD. Overrun control keeps only bit 12, and the divisor keeps 16 bits.
- R3: The transmit data register stores only bits 7:0. Writing 0xFFFFFFFF reads back 0x000000FF.
- R4: One bit lasts exactly divisor clock cycles when the divisor is a multiple of 16. A divisor below 16 acts as 16.
- R5: With the port and transmitter on, a pending byte goes out as a low start bit, eight data bits LSB first, then a high stop bit. The line idles high.
- R6: Status bit 7 (transmit-empty) clears on a write to transmit data. It sets again when the byte moves into the shift register. It stays clear while the transmitter is off.
- R7: The receiver checks the start bit again at mid-bit. A low pulse shorter than half a bit is ignored. Nothing is received while the port or the receiver is off.
- R8: A completed frame stores its byte and sets status bit 5 (receive-not-empty). Reading receive data returns the byte and clears bit 5.
- R9: With overrun control bit 12 clear, a frame that completes while bit 5 is set sets status bit 3 (overrun), and the receive register keeps the earlier byte.
- R10: With overrun control bit 12 set, such a frame overwrites the receive register and status bit 3 stays clear.
- R11: Writing 1 to bit 3 of the flag-clear register clears the overrun flag.
- R12: `irq` = (transmit-empty AND control bit 7) OR ((receive-not-empty OR overrun) AND control bit 5).
- R13: If a receive-data read falls in the same cycle as a frame completion, the read returns the older byte. The new byte is stored, bit 5 stays set and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Combined interrupt request |

## Verification
Two things can land on the same clock edge: a software read of the receive register and the receiver finishing a frame. If that coincidence were handled wrongly, the block would report a false overrun or lose a byte. The bench first measures, through the status port, how many cycles pass from the start of a frame to the receive flag rising, with the divisor set so that every cycle carries a tick. It then leaves one byte unread and sends a second. The read is placed exactly one cycle before the measured arrival, so its strobe shares the completing edge. The bench checks that the read returns the first byte, that the status word afterwards shows receive-not-empty without overrun, and that a further read returns the second byte.

// File: rtl/sport_pkg.sv
package sport_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 6;

    // register byte offsets
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_OVRC  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_DIV   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_RXD   = 6'h24;
    localparam logic [ADDR_W-1:0] OFS_TXD   = 6'h28;

    // control field positions
    localparam int CB_EN     = 0;
    localparam int CB_RXON   = 2;
    localparam int CB_TXON   = 3;
    localparam int CB_RXIE   = 5;
    localparam int CB_TXIE   = 7;
    localparam int CB_OVRDIS = 12;

    // status field positions
    localparam int SB_TXE  = 7;
    localparam int SB_RXNE = 5;
    localparam int SB_ORE  = 3;

    typedef struct packed {
        logic txe_ie;
        logic rxne_ie;
        logic tx_on;
        logic rx_on;
        logic en;
    } ctrl_t;

    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_START = 2'd1,
        LN_DATA  = 2'd2,
        LN_STOP  = 2'd3
    } line_state_e;

    function automatic ctrl_t word_to_ctrl(input logic [BUS_W-1:0] w);
        ctrl_t c;
        c.en      = w[CB_EN];
        c.rx_on   = w[CB_RXON];
        c.tx_on   = w[CB_TXON];
        c.rxne_ie = w[CB_RXIE];
        c.txe_ie  = w[CB_TXIE];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [BUS_W-1:0] w;
        w           = '0;
        w[CB_EN]    = c.en;
        w[CB_RXON]  = c.rx_on;
        w[CB_TXON]  = c.tx_on;
        w[CB_RXIE]  = c.rxne_ie;
        w[CB_TXIE]  = c.txe_ie;
        return w;
    endfunction

    function automatic logic [BUS_W-1:0] status_word(input logic txe,
                                                     input logic rxne,
                                                     input logic ore);
        logic [BUS_W-1:0] w;
        w          = '0;
        w[SB_TXE]  = txe;
        w[SB_RXNE] = rxne;
        w[SB_ORE]  = ore;
        return w;
    endfunction

endpackage

// File: rtl/sport_baudgen.sv
module sport_baudgen #(
    parameter int DIV_W = 16,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    localparam int ACC_W = DIV_W + 1;
    localparam logic [ACC_W-1:0] OVS_V     = ACC_W'(OVS);
    localparam logic [ACC_W-1:0] TWO_OVS_V = ACC_W'(2 * OVS);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] eff_div;

    always_comb begin
        eff_div = ({1'b0, div_i} < OVS_V) ? OVS_V : {1'b0, div_i};
        sum     = acc_q + OVS_V;
        tick_o  = en_i && (sum >= eff_div);
    end

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            acc_q <= '0;
        end else if (tick_o) begin
            acc_q <= sum - eff_div;
        end else begin
            acc_q <= sum;
        end
    end

    // R4
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_o && ({1'b0, div_i} >= TWO_OVS_V))
            |=> (!tick_o || (div_i != $past(div_i))));

endmodule

// File: rtl/sport_tx.sv
module sport_tx
    import sport_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_i,
    input  logic                 en_i,
    input  logic                 pend_i,
    input  logic [DATA_BITS-1:0] data_i,
    output logic                 take_o,
    output logic                 txd_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

    line_state_e          st_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [IDX_W-1:0]     idx_q;
    logic [DATA_BITS-1:0] sh_q;
    logic                 bit_end;

    assign take_o  = (st_q == LN_IDLE) && en_i && pend_i;
    assign bit_end = tick_i && (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= LN_IDLE;
            cnt_q <= '0;
            idx_q <= '0;
            sh_q  <= '0;
        end else if (!en_i) begin
            st_q  <= LN_IDLE;
            cnt_q <= '0;
        end else if (st_q == LN_IDLE) begin
            if (take_o) begin
                sh_q  <= data_i;
                st_q  <= LN_START;
                cnt_q <= '0;
                idx_q <= '0;
            end
        end else if (tick_i) begin
            cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
            if (bit_end) begin
                case (st_q)
                    LN_START: st_q <= LN_DATA;
                    LN_DATA: begin
                        sh_q  <= sh_q >> 1;
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == IDX_LAST) st_q <= LN_STOP;
                    end
                    default: st_q <= LN_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        case (st_q)
            LN_START: txd_o = 1'b0;
            LN_DATA:  txd_o = sh_q[0];
            default:  txd_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/sport_rx.sv
module sport_rx
    import sport_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_i,
    input  logic                 en_i,
    input  logic                 rxd_i,
    output logic                 done_o,
    output logic [DATA_BITS-1:0] data_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_BITS - 1);

    logic                 s1_q, s2_q;
    line_state_e          st_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [IDX_W-1:0]     idx_q;
    logic [DATA_BITS-1:0] sh_q;
    logic                 bit_end;

    assign bit_end = tick_i && (cnt_q == CNT_LAST);
    assign done_o  = (st_q == LN_STOP) && bit_end;
    assign data_o  = sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= rxd_i;
            s2_q <= s1_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= LN_IDLE;
            cnt_q <= '0;
            idx_q <= '0;
            sh_q  <= '0;
        end else if (!en_i) begin
            st_q  <= LN_IDLE;
            cnt_q <= '0;
        end else if (tick_i) begin
            case (st_q)
                LN_IDLE: begin
                    if (!s2_q) begin
                        st_q  <= LN_START;
                        cnt_q <= '0;
                    end
                end
                LN_START: begin
                    if (cnt_q == HALF_LAST) begin
                        cnt_q <= '0;
                        idx_q <= '0;
                        st_q  <= s2_q ? LN_IDLE : LN_DATA;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                LN_DATA: begin
                    if (bit_end) begin
                        sh_q  <= {s2_q, sh_q[DATA_BITS-1:1]};
                        cnt_q <= '0;
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == IDX_LAST) st_q <= LN_STOP;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (bit_end) begin
                        st_q  <= LN_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: rtl/serial_port_core.sv
module serial_port_core
    import sport_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int OVS       = 16,
    parameter int DATA_BITS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              rxd,
    output logic              txd,
    output logic              irq
);
    ctrl_t                ctrl_q;
    logic                 ovr_dis_q;
    logic [DIV_W-1:0]     div_q;
    logic                 txe_q;
    logic [DATA_BITS-1:0] tx_hold_q;
    logic                 rxne_q;
    logic                 ore_q;
    logic [DATA_BITS-1:0] rx_data_q;

    logic wr, rd;
    logic wr_ctrl, wr_ovrc, wr_div, wr_clr, wr_txd, rd_rx;
    logic tick, tx_take, rx_done, rx_held;
    logic [DATA_BITS-1:0] rx_byte;

    always_comb begin
        wr      = bus_en && bus_we;
        rd      = bus_en && !bus_we;
        wr_ctrl = wr && (bus_addr == OFS_CTRL);
        wr_ovrc = wr && (bus_addr == OFS_OVRC);
        wr_div  = wr && (bus_addr == OFS_DIV);
        wr_clr  = wr && (bus_addr == OFS_CLR);
        wr_txd  = wr && (bus_addr == OFS_TXD);
        rd_rx   = rd && (bus_addr == OFS_RXD);
        rx_held = rxne_q && !rd_rx;
    end

    sport_baudgen #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
        .clk    (clk),
        .rst    (rst),
        .en_i   (ctrl_q.en),
        .div_i  (div_q),
        .tick_o (tick)
    );

    sport_tx #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_tx (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .en_i   (ctrl_q.en && ctrl_q.tx_on),
        .pend_i (!txe_q),
        .data_i (tx_hold_q),
        .take_o (tx_take),
        .txd_o  (txd)
    );

    sport_rx #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .en_i   (ctrl_q.en && ctrl_q.rx_on),
        .rxd_i  (rxd),
        .done_o (rx_done),
        .data_o (rx_byte)
    );

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            ovr_dis_q <= 1'b0;
            div_q     <= '0;
        end else begin
            if (wr_ctrl) ctrl_q    <= word_to_ctrl(bus_wdata);
            if (wr_ovrc) ovr_dis_q <= bus_wdata[CB_OVRDIS];
            if (wr_div)  div_q     <= bus_wdata[DIV_W-1:0];
        end
    end

    // transmit holding register; a write in the take cycle wins
    always_ff @(posedge clk) begin
        if (rst) begin
            txe_q     <= 1'b1;
            tx_hold_q <= '0;
        end else begin
            if (tx_take) txe_q <= 1'b1;
            if (wr_txd) begin
                tx_hold_q <= bus_wdata[DATA_BITS-1:0];
                txe_q     <= 1'b0;
            end
        end
    end

    // receive holding register and flags; a same-cycle read frees the slot
    always_ff @(posedge clk) begin
        if (rst) begin
            rxne_q    <= 1'b0;
            ore_q     <= 1'b0;
            rx_data_q <= '0;
        end else begin
            if (wr_clr && bus_wdata[SB_ORE]) ore_q <= 1'b0;
            if (rd_rx) rxne_q <= 1'b0;
            if (rx_done) begin
                if (rx_held && !ovr_dis_q) begin
                    ore_q <= 1'b1;
                end else begin
                    rx_data_q <= rx_byte;
                    rxne_q    <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_CTRL: bus_rdata = ctrl_to_word(ctrl_q);
            OFS_OVRC: bus_rdata = BUS_W'({ovr_dis_q, {CB_OVRDIS{1'b0}}});
            OFS_DIV:  bus_rdata = BUS_W'(div_q);
            OFS_STAT: bus_rdata = status_word(txe_q, rxne_q, ore_q);
            OFS_RXD:  bus_rdata = BUS_W'(rx_data_q);
            OFS_TXD:  bus_rdata = BUS_W'(tx_hold_q);
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = (txe_q && ctrl_q.txe_ie) || ((rxne_q || ore_q) && ctrl_q.rxne_ie);

    // R9
    ore_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ore_q) |-> ($past(rxne_q) && !$past(ovr_dis_q)));

    // R9
    rxdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rxne_q && !ovr_dis_q && !rd_rx) |=> $stable(rx_data_q));

    // R6
    txe_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(txe_q) |-> $past(wr_txd));

endmodule

// File: tb/serial_port_core_tb.sv
module serial_port_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BIT16 = 16;
    localparam logic [5:0] A_CTRL = 6'h00, A_OVRC = 6'h08, A_DIV = 6'h0C,
                           A_STAT = 6'h1C, A_CLR = 6'h20, A_RXD = 6'h24, A_TXD = 6'h28;
    localparam logic [7:0] VEC [6] = '{8'h55, 8'hA3, 8'h00, 8'hFF, 8'h81, 8'h3C};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rxd = 1'b1;
    logic        txd, irq;

    int checks = 0;
    int failures = 0;
    int lat = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_port_core u_dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_en = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        check(req, v, exp);
    endtask

    task automatic send_rx(input logic [7:0] b, input int bc);
        @(negedge clk); rxd = 1'b0;
        repeat (bc) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (bc) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (bc) @(negedge clk);
    endtask

    task automatic capture_tx(output logic [7:0] b, output logic ok, input int bc);
        int w;
        w = 0; ok = 1'b1; b = '0;
        @(negedge clk);
        while (txd !== 1'b0 && w < 3000) begin @(negedge clk); w++; end
        if (w >= 3000) ok = 1'b0;
        repeat (bc/2) @(negedge clk);
        if (txd !== 1'b0) ok = 1'b0;
        for (int i = 0; i < 8; i++) begin
            repeat (bc) @(negedge clk);
            b[i] = txd;
        end
        repeat (bc) @(negedge clk);
        if (txd !== 1'b1) ok = 1'b0;
    endtask

    task automatic tx_and_check(input string req, input logic [31:0] ctrl_or_data,
                                input logic [5:0] a, input logic [7:0] exp, input int bc);
        logic [7:0] got;
        logic ok;
        fork
            bus_write(a, ctrl_or_data);
            capture_tx(got, ok, bc);
        join
        check(req, {23'd0, ok, got}, {23'd0, 1'b1, exp});
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog (any requirement) actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        check("R1 txd idle", {31'd0, txd}, 32'd1);
        check("R1 irq low", {31'd0, irq}, 32'd0);
        expect_reg("R1 status", A_STAT, 32'h80);
        expect_reg("R1 control", A_CTRL, 32'h0);
        expect_reg("R1 divisor", A_DIV, 32'h0);

        // R2 register map and kept fields
        bus_write(A_CTRL, 32'hFFFF_FFFF);
        expect_reg("R2 control fields", A_CTRL, 32'hAD);
        bus_write(A_CTRL, 32'h0);
        bus_write(A_OVRC, 32'hFFFF_FFFF);
        expect_reg("R2 overrun ctrl field", A_OVRC, 32'h1000);
        bus_write(A_OVRC, 32'h0);
        bus_write(A_DIV, 32'hFFFF_FFFF);
        expect_reg("R2 divisor width", A_DIV, 32'hFFFF);
        bus_write(A_DIV, 32'd16);

        // R3 / R6 with transmitter off
        bus_write(A_TXD, 32'hFFFF_FFFF);
        expect_reg("R3 tx data low byte", A_TXD, 32'hFF);
        repeat (40) @(negedge clk);
        expect_reg("R6 txe stays clear while off", A_STAT, 32'h00);
        tx_and_check("R5 pending byte sent on enable", 32'h0D, A_CTRL, 8'hFF, BIT16);
        expect_reg("R6 txe set after handoff", A_STAT, 32'h80);

        // vector table: receive then transmit each byte
        foreach (VEC[k]) begin
            send_rx(VEC[k], BIT16);
            expect_reg("R8 rxne after frame", A_STAT, 32'hA0);
            expect_reg("R8 rx byte", A_RXD, {24'd0, VEC[k]});
            expect_reg("R8 rxne cleared by read", A_STAT, 32'h80);
            tx_and_check("R5 tx frame", {24'd0, VEC[k]}, A_TXD, VEC[k], BIT16);
        end

        // R7 false start
        @(negedge clk); rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (300) @(negedge clk);
        expect_reg("R7 glitch ignored", A_STAT, 32'h80);

        // calibration: cycles from start edge to rxne visible
        fork
            send_rx(8'hC4, BIT16);
            begin
                logic [31:0] s;
                lat = 0;
                s = '0;
                while (s[5] !== 1'b1 && lat < 400) begin
                    bus_read(A_STAT, s);
                    lat++;
                end
            end
        join
        check("R8 rxne rises within frame", {31'd0, lat < 400}, 32'd1);
        expect_reg("R8 byte after false start", A_RXD, 32'hC4);

        // R9 / R12 overrun with old byte held
        @(negedge clk);
        check("R12 irq low with enables clear", {31'd0, irq}, 32'd0);
        send_rx(8'h11, BIT16);
        send_rx(8'h22, BIT16);
        expect_reg("R9 overrun flagged", A_STAT, 32'hA8);
        @(negedge clk);
        check("R12 overrun no irq without enable", {31'd0, irq}, 32'd0);
        bus_write(A_CTRL, 32'h2D);
        @(negedge clk);
        check("R12 irq with receive enable", {31'd0, irq}, 32'd1);
        expect_reg("R9 earlier byte kept", A_RXD, 32'h11);
        expect_reg("R9 overrun persists after read", A_STAT, 32'h88);
        @(negedge clk);
        check("R12 irq held by overrun", {31'd0, irq}, 32'd1);
        bus_write(A_CLR, 32'h08);
        expect_reg("R11 overrun cleared", A_STAT, 32'h80);
        @(negedge clk);
        check("R12 irq drops after clear", {31'd0, irq}, 32'd0);

        // R10 overwrite policy
        bus_write(A_OVRC, 32'h1000);
        send_rx(8'h33, BIT16);
        send_rx(8'h44, BIT16);
        expect_reg("R10 no overrun flag", A_STAT, 32'hA0);
        expect_reg("R10 newer byte", A_RXD, 32'h44);
        bus_write(A_OVRC, 32'h0);

        // R12 transmit-empty source
        bus_write(A_CTRL, 32'h8D);
        @(negedge clk);
        check("R12 irq from txe", {31'd0, irq}, 32'd1);
        bus_write(A_CTRL, 32'h85);
        bus_write(A_TXD, 32'h5A);
        @(negedge clk);
        check("R12 irq falls with txe", {31'd0, irq}, 32'd0);
        tx_and_check("R5 resumed transmit", 32'h0D, A_CTRL, 8'h5A, BIT16);

        // R13 read coinciding with frame completion
        send_rx(8'h6B, BIT16);
        fork
            send_rx(8'h9E, BIT16);
            begin
                logic [31:0] r;
                repeat (lat - 2) @(negedge clk);
                bus_read(A_RXD, r);
                check("R13 read returns older byte", r, 32'h6B);
            end
        join
        expect_reg("R13 rxne kept, no overrun", A_STAT, 32'hA0);
        expect_reg("R13 newer byte stored", A_RXD, 32'h9E);

        // R4 bit period equals divisor
        bus_write(A_DIV, 32'd32);
        fork
            bus_write(A_TXD, 32'h0F);
            begin
                int w, hi;
                w = 0; hi = 0;
                @(negedge clk);
                while (txd !== 1'b0 && w < 2000) begin @(negedge clk); w++; end
                while (txd !== 1'b1 && w < 2000) begin @(negedge clk); w++; end
                while (txd === 1'b1 && hi < 1000) begin @(negedge clk); hi++; end
                check("R4 four bits at divisor 32", hi, 32'd128);
            end
        join
        repeat (300) @(negedge clk);
        bus_write(A_DIV, 32'd5);
        tx_and_check("R4 small divisor acts as 16", 32'hB7, A_TXD, 8'hB7, BIT16);

        // R7 receiver off
        bus_write(A_DIV, 32'd16);
        bus_write(A_CTRL, 32'h09);
        send_rx(8'h77, BIT16);
        repeat (20) @(negedge clk);
        expect_reg("R7 receiver off ignores frame", A_STAT, 32'h80);

        finish_run();
    end
endmodule